// File: doc/BRIEF.md
# Shared-Counter Compare and Event Pulse Unit

This block watches the counter of the reference PWM channel (channel 0) and its count direction. It holds a bank of identical comparison slots, eight by default. Each slot has a compare value, an enable bit and a direction qualifier. When a slot sees the counter reach its value, it produces a single hit. The hit sets a sticky match flag, which an interrupt controller can read. Software clears the flags with a single strobe.

Hits are routed through per-line masks to two event outputs and to a DMA request output. The event outputs are meant for timing ADC conversions independently of the PWM waveforms. Each event output and the DMA request give a one-cycle pulse.

Slot settings are written through a simple write port into shadow registers. They reach the active compare logic only at the end of a counter period, so a period never mixes old and new settings. Routing masks, in contrast, apply as soon as they are written.

Top module: `cmp_event_unit`

## Requirements
- R1: While reset is low, and right after it, every match flag, both event outputs and the DMA request are 0. All slots start disabled and all masks start at zero.
- R2: An active slot hits when its enable bit is 1, the counter equals its compare value, and its direction field allows the current direction. The direction field is 2'b01 for up only (`cnt_down`=0), 2'b10 for down only (`cnt_down`=1), and 2'b00 or 2'b11 for either direction.
- R3: A match condition that holds over consecutive cycles produces exactly one hit, in its first cycle. The slot's flag reads 1 from the following cycle.
- R4: Match flags stay set until `flag_clr` is pulsed. A hit in the same cycle as the clear leaves that slot's flag set.
- R5: A write to slot address i (0 to NUM_CMP-1) goes to a shadow register. The write data fields are value in [CNT_W-1:0], enable in bit CNT_W, and direction in [CNT_W+2:CNT_W+1]. The shadow contents become active at the clock edge where `period_end` is 1. A write made in that same cycle takes effect only at the next period end.
- R6: Event line e has its mask at address NUM_CMP+e, where bit i selects slot i. The line pulses high for one cycle, in the cycle after a hit of any slot selected in its mask.
- R7: The DMA mask is at address NUM_CMP+NUM_EVT, where bit i selects slot i. `dma_req` pulses for one cycle, in the cycle after a hit of any selected slot.
- R8: A mask write governs routing from the cycle after the write.
- R9: A slot whose active enable bit is 0 never hits, sets no flag and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CNT_W | Counter value of channel 0 |
| cnt_down | input | 1 | 1 while channel 0 counts down |
| period_end | input | 1 | End of channel 0 period; loads the shadow slot settings |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| flag_clr | input | 1 | Clears all match flags |
| match_flags | output | NUM_CMP | Sticky match flag for each slot |
| evt_pulse | output | NUM_EVT | One-cycle event pulses |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
A wrong active setting or a lost shadow load shows up as a flag that sets at the wrong counter value, or in the wrong period. The reference model sees the difference in the cycle after that counter value is presented. A stuck edge-detect register shows up as a missing hit, or as a second pulse, one cycle after a held counter value. A bad mask decode shows up as an event or DMA pulse on the wrong output in that same cycle. Because outputs are compared every clock, each such fault becomes visible no later than the first period that reaches the affected value.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

   typedef enum logic [1:0] {
      DIR_EITHER     = 2'b00,
      DIR_UP_ONLY    = 2'b01,
      DIR_DOWN_ONLY  = 2'b10,
      DIR_EITHER_ALT = 2'b11
   } cmp_dir_e;

   // True when a slot qualified by d may hit while the counter moves in direction down
   function automatic logic dir_allows(input cmp_dir_e d, input logic down);
      case (d)
         DIR_UP_ONLY:   return !down;
         DIR_DOWN_ONLY: return down;
         default:       return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/cmp_cfg_bank.sv
module cmp_cfg_bank #(
   parameter int NUM_CMP = 8,
   parameter int NUM_EVT = 2,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 19
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               period_end,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   output logic [NUM_CMP-1:0][CNT_W-1:0]      act_val,
   output logic [NUM_CMP-1:0]                 act_en,
   output logic [NUM_CMP-1:0][1:0]            act_dir,
   output logic [NUM_EVT-1:0][NUM_CMP-1:0]    evt_mask,
   output logic [NUM_CMP-1:0]                 dma_mask
);
   localparam int SLOT_W = CNT_W + 3;
   localparam logic [ADDR_W-1:0] DMA_ADDR = ADDR_W'(NUM_CMP + NUM_EVT);

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(i);
      logic [SLOT_W-1:0] shadow_q;
      logic [SLOT_W-1:0] active_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
         end else begin
            if (period_end)
               active_q <= shadow_q;
            if (wr_en && wr_addr == SLOT_ADDR)
               shadow_q <= wr_data[SLOT_W-1:0];
         end
      end

      assign act_val[i] = active_q[CNT_W-1:0];
      assign act_en[i]  = active_q[CNT_W];
      assign act_dir[i] = active_q[CNT_W+2:CNT_W+1];
   end

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt_mask
      localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_CMP + e);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            evt_mask[e] <= '0;
         else if (wr_en && wr_addr == MASK_ADDR)
            evt_mask[e] <= wr_data[NUM_CMP-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dma_mask <= '0;
      else if (wr_en && wr_addr == DMA_ADDR)
         dma_mask <= wr_data[NUM_CMP-1:0];
   end

endmodule

// File: rtl/cmp_slot.sv
module cmp_slot
   import cmp_evt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             cmp_en,
   input  logic [1:0]       cmp_dir,
   output logic             hit
);
   logic eq_now;
   logic eq_prev_q;

   assign eq_now = cmp_en && (cnt_val == cmp_val)
                   && dir_allows(cmp_dir_e'(cmp_dir), cnt_down);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         eq_prev_q <= 1'b0;
      else
         eq_prev_q <= eq_now;
   end

   // a held counter value yields a single hit on entry
   assign hit = eq_now && !eq_prev_q;

endmodule

// File: rtl/evt_router.sv
module evt_router #(
   parameter int NUM_CMP = 8,
   parameter int NUM_EVT = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CMP-1:0]              hit,
   input  logic                            flag_clr,
   input  logic [NUM_EVT-1:0][NUM_CMP-1:0] evt_mask,
   input  logic [NUM_CMP-1:0]              dma_mask,
   output logic [NUM_CMP-1:0]              match_flags,
   output logic [NUM_EVT-1:0]              evt_pulse,
   output logic                            dma_req
);
   logic [NUM_EVT-1:0] evt_next;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_line
      assign evt_next[e] = |(hit & evt_mask[e]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_flags <= '0;
         evt_pulse   <= '0;
         dma_req     <= 1'b0;
      end else begin
         match_flags <= (match_flags & ~{NUM_CMP{flag_clr}}) | hit;
         evt_pulse   <= evt_next;
         dma_req     <= |(hit & dma_mask);
      end
   end

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit #(
   parameter int  NUM_CMP = 8,
   parameter int  NUM_EVT = 2,
   parameter int  CNT_W   = 16,
   localparam int ADDR_W  = $clog2(NUM_CMP + NUM_EVT + 1),
   localparam int DATA_W  = (CNT_W + 3 > NUM_CMP) ? CNT_W + 3 : NUM_CMP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt_val,
   input  logic               cnt_down,
   input  logic               period_end,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               flag_clr,
   output logic [NUM_CMP-1:0] match_flags,
   output logic [NUM_EVT-1:0] evt_pulse,
   output logic               dma_req
);
   if (NUM_CMP < 1 || NUM_CMP > 64) begin : g_bad_cmp
      $error("cmp_event_unit: NUM_CMP must lie in 1..64");
   end
   if (NUM_EVT < 1 || NUM_EVT > 8) begin : g_bad_evt
      $error("cmp_event_unit: NUM_EVT must lie in 1..8");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cmp_event_unit: CNT_W must be at least 2");
   end

   logic [NUM_CMP-1:0][CNT_W-1:0]   act_val;
   logic [NUM_CMP-1:0]              act_en;
   logic [NUM_CMP-1:0][1:0]         act_dir;
   logic [NUM_EVT-1:0][NUM_CMP-1:0] evt_mask;
   logic [NUM_CMP-1:0]              dma_mask;
   logic [NUM_CMP-1:0]              hit_vec;

   cmp_cfg_bank #(
      .NUM_CMP(NUM_CMP), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .period_end(period_end),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .act_val(act_val), .act_en(act_en), .act_dir(act_dir),
      .evt_mask(evt_mask), .dma_mask(dma_mask)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      cmp_slot #(.CNT_W(CNT_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .cnt_val(cnt_val), .cnt_down(cnt_down),
         .cmp_val(act_val[i]), .cmp_en(act_en[i]), .cmp_dir(act_dir[i]),
         .hit(hit_vec[i])
      );
   end

   evt_router #(.NUM_CMP(NUM_CMP), .NUM_EVT(NUM_EVT)) u_route (
      .clk(clk), .rst_n(rst_n), .hit(hit_vec), .flag_clr(flag_clr),
      .evt_mask(evt_mask), .dma_mask(dma_mask),
      .match_flags(match_flags), .evt_pulse(evt_pulse), .dma_req(dma_req)
   );

endmodule

// File: rtl/cmp_event_unit_chk.sv
module cmp_event_unit_chk #(
   parameter int NUM_CMP = 8,
   parameter int NUM_EVT = 2,
   parameter int CNT_W   = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            period_end,
   input logic                            flag_clr,
   input logic [NUM_CMP-1:0]              hit_vec,
   input logic [NUM_CMP-1:0][CNT_W-1:0]   act_val,
   input logic [NUM_CMP-1:0]              act_en,
   input logic [NUM_CMP-1:0][1:0]         act_dir,
   input logic [NUM_EVT-1:0][NUM_CMP-1:0] evt_mask,
   input logic [NUM_CMP-1:0]              dma_mask,
   input logic [NUM_CMP-1:0]              match_flags,
   input logic [NUM_EVT-1:0]              evt_pulse,
   input logic                            dma_req
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (match_flags == '0 && evt_pulse == '0 && !dma_req));

   // R3
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & $past(hit_vec)) == '0);

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> ((match_flags & $past(hit_vec)) == $past(hit_vec)));

   // R4
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr |=> ((match_flags & $past(match_flags)) == $past(match_flags)));

   // R4
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && hit_vec == '0) |=> match_flags == '0);

   // R5
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> ($stable(act_val) && $stable(act_en) && $stable(act_dir)));

   // R7
   dma_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit_vec & dma_mask)) |=> dma_req);

   // R7
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(hit_vec & dma_mask)) |=> !dma_req);

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      // R6
      evt_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|(hit_vec & evt_mask[e])) |=> evt_pulse[e]);
      // R6
      evt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(hit_vec & evt_mask[e])) |=> !evt_pulse[e]);
   end

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
      // R9
      disabled_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !act_en[i] |-> !hit_vec[i]);
   end

endmodule

bind cmp_event_unit cmp_event_unit_chk #(
   .NUM_CMP(NUM_CMP), .NUM_EVT(NUM_EVT), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .period_end(period_end), .flag_clr(flag_clr),
   .hit_vec(hit_vec), .act_val(act_val), .act_en(act_en), .act_dir(act_dir),
   .evt_mask(evt_mask), .dma_mask(dma_mask),
   .match_flags(match_flags), .evt_pulse(evt_pulse), .dma_req(dma_req)
);

// File: tb/test_cmp_event_unit.sv
module test_cmp_event_unit;
   localparam int NC = 8;
   localparam int NE = 2;
   localparam int CW = 16;
   localparam int AW = 4;
   localparam int DW = 19;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [CW-1:0] cnt_val = '0;
   logic          cnt_down = 1'b0;
   logic          period_end = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          flag_clr = 1'b0;
   logic [NC-1:0] match_flags;
   logic [NE-1:0] evt_pulse;
   logic          dma_req;

   cmp_event_unit #(.NUM_CMP(NC), .NUM_EVT(NE), .CNT_W(CW)) i_cmp_event_unit (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .period_end(period_end), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .flag_clr(flag_clr),
      .match_flags(match_flags), .evt_pulse(evt_pulse), .dma_req(dma_req)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [CW-1:0] m_shv [NC];
   logic [CW-1:0] m_acv [NC];
   logic          m_she [NC];
   logic          m_ace [NC];
   logic [1:0]    m_shd [NC];
   logic [1:0]    m_acd [NC];
   logic [NC-1:0] m_prev = '0;
   logic [NC-1:0] m_flags = '0;
   logic [NC-1:0] m_mask [NE];
   logic [NC-1:0] m_dmask = '0;
   logic [NE-1:0] m_evt = '0;
   logic          m_dma = 1'b0;

   function automatic bit dir_ok(logic [1:0] d, logic dn);
      if (d == 2'b01) return !dn;
      if (d == 2'b10) return dn;
      return 1'b1;
   endfunction

   function automatic logic [DW-1:0] slot_word(logic [1:0] d, logic en, int v);
      return {d, en, CW'(v)};
   endfunction

   task automatic check(string tag);
      vectors++;
      if (match_flags !== m_flags) begin
         miscompares++;
         $display("FAIL %s match_flags act=%b exp=%b t=%0t", tag, match_flags, m_flags, $time);
      end
      vectors++;
      if (evt_pulse !== m_evt) begin
         miscompares++;
         $display("FAIL %s evt_pulse act=%b exp=%b t=%0t", tag, evt_pulse, m_evt, $time);
      end
      vectors++;
      if (dma_req !== m_dma) begin
         miscompares++;
         $display("FAIL %s dma_req act=%b exp=%b t=%0t", tag, dma_req, m_dma, $time);
      end
   endtask

   // called at a falling edge: drive, predict the next rising edge, compare at the next falling edge
   task automatic step(int cnt, bit dn, bit pe, bit we, int a, logic [DW-1:0] d, bit clr, string tag);
      logic [NC-1:0] raw;
      logic [NC-1:0] hit;
      cnt_val = CW'(cnt); cnt_down = dn; period_end = pe;
      wr_en = we; wr_addr = AW'(a); wr_data = d; flag_clr = clr;
      for (int i = 0; i < NC; i++)
         raw[i] = m_ace[i] && (m_acv[i] == CW'(cnt)) && dir_ok(m_acd[i], dn);
      hit = raw & ~m_prev;
      m_prev = raw;
      m_flags = (clr ? '0 : m_flags) | hit;
      for (int e = 0; e < NE; e++) m_evt[e] = |(hit & m_mask[e]);
      m_dma = |(hit & m_dmask);
      if (pe)
         for (int i = 0; i < NC; i++) begin
            m_acv[i] = m_shv[i]; m_ace[i] = m_she[i]; m_acd[i] = m_shd[i];
         end
      if (we) begin
         if (a < NC) begin
            m_shv[a] = d[CW-1:0]; m_she[a] = d[CW]; m_shd[a] = d[CW+2:CW+1];
         end else if (a < NC + NE) m_mask[a-NC] = d[NC-1:0];
         else if (a == NC + NE) m_dmask = d[NC-1:0];
      end
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   // triangle period: up 0..top-1, down top..1, each value held `hold` cycles
   task automatic run_period(int top, int hold, bit we, int a, logic [DW-1:0] d, int clr_at, string tag);
      for (int v = 0; v < top; v++)
         for (int h = 0; h < hold; h++)
            step(v, 1'b0, (v == 0 && h == 0), we && v == 0 && h == 0, a, d,
                 (v == clr_at && h == 0), tag);
      for (int v = top; v > 0; v--)
         for (int h = 0; h < hold; h++)
            step(v, 1'b1, 1'b0, 1'b0, 0, '0, 1'b0, tag);
   endtask

   initial begin
      for (int i = 0; i < NC; i++) begin
         m_shv[i] = '0; m_acv[i] = '0; m_she[i] = 1'b0;
         m_ace[i] = 1'b0; m_shd[i] = '0; m_acd[i] = '0;
      end
      for (int e = 0; e < NE; e++) m_mask[e] = '0;

      // R1: reset state
      repeat (3) begin @(negedge clk); check("R1"); end
      rst_n = 1'b1;
      step(0, 0, 0, 0, 0, '0, 0, "R1");

      // R5: program shadows, no period end yet
      step(0, 0, 0, 1, 0, slot_word(2'b00, 1, 5), 0, "R5");
      step(0, 0, 0, 1, 1, slot_word(2'b01, 1, 10), 0, "R5");
      step(0, 0, 0, 1, 2, slot_word(2'b10, 1, 10), 0, "R5");
      step(0, 0, 0, 1, 3, slot_word(2'b00, 0, 3), 0, "R9");
      step(0, 0, 0, 1, 4, slot_word(2'b11, 1, 7), 0, "R5");
      step(0, 0, 0, 1, 8, DW'(8'h03), 0, "R6");
      step(0, 0, 0, 1, 9, DW'(8'h14), 0, "R6");
      step(0, 0, 0, 1, 10, DW'(8'h10), 0, "R7");
      // counter sweeps past every value while settings are only shadowed
      for (int v = 0; v < 12; v++) step(v, 0, 0, 0, 0, '0, 0, "R5");

      // R2, R6, R7: settings active, both directions
      run_period(12, 1, 0, 0, '0, -1, "R2");
      // R3: held counter values give one hit each
      run_period(12, 2, 0, 0, '0, 3, "R3");
      // R4: clear coincides with slot 0 hit at value 5
      run_period(12, 1, 0, 0, '0, 5, "R4");
      run_period(12, 1, 0, 0, '0, 1, "R4");
      // R5: write in the period-end cycle waits one more period
      run_period(12, 1, 1, 0, slot_word(2'b00, 1, 8), 2, "R5");
      run_period(12, 1, 0, 0, '0, 2, "R5");
      // R8: mask changes take effect immediately
      step(0, 0, 0, 1, 8, DW'(8'h01), 1, "R8");
      step(1, 0, 0, 1, 10, DW'(8'h06), 0, "R8");
      run_period(12, 1, 0, 0, '0, 2, "R8");
      run_period(12, 1, 0, 0, '0, 2, "R7");
      // R9: disable slot 4 through the shadow path
      run_period(12, 1, 1, 4, slot_word(2'b00, 0, 7), 2, "R9");
      run_period(12, 1, 0, 0, '0, 2, "R9");
      run_period(12, 2, 0, 0, '0, 9, "R2");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog (R1..all) act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule